// File: doc/BRIEF.md
# Direction-Switched Byte Buffer with Level Flag and Interrupt Gating

This block sits between a host and the serial engine of a flash controller that moves data indirectly through a small on-chip buffer. It holds up to 16 bytes. A direction field picks who fills and who empties the buffer. In write direction the host pushes bytes and the engine pulls them out toward the flash. In read direction the engine pushes bytes it received and the host pulls them. Each data side is a valid/ready stream. A transfer happens on a rising clock edge where both valid and ready are high. The consumer of a pop port may hold ready high for as long as it likes, but a pop happens only while valid is high.

A 4-bit threshold code N defines a level of N+1 bytes. The level flag compares that level with free space in write direction and with stored bytes in read direction. It is a combinational function of the stored-byte count, so it follows each push and pop with no extra latency. Three event inputs (transfer done, transfer error, status match) are latched into sticky bits. Each sticky bit, and the live level flag, passes through its own enable into a single interrupt line. A control word holds the threshold, direction, enables and the flash-select fields. The two flash-select fields only accept writes while the engine reports busy low.

Top module: `ffc_top`

## Requirements
- R1: The buffer returns bytes in the order they were pushed and holds at most 16. The active push port's ready is low exactly when 16 bytes are stored, and the active pop port's valid is high exactly when at least one byte is stored.
- R2: Direction code 00 (control bits [5:4]) connects the host push port and the engine pop port. Direction code 01 connects the engine push port and the host pop port. The unselected ports keep ready and valid low. Codes 10 and 11 connect neither side.
- R3: In direction 00 with threshold code N (control bits [3:0]), `lvl_flag` is high exactly when 16 minus the stored count is at least N+1.
- R4: In direction 01 with threshold code N, `lvl_flag` is high exactly when the stored count is at least N+1.
- R5: `lvl_flag` reflects the count present after the clock edge of a push or pop, in that same cycle. It is low for direction codes 10 and 11.
- R6: `irq` is the OR of each latched event ANDed with its enable and of the live `lvl_flag` ANDed with the threshold enable. The enable bits are: transfer-error enable at control bit 6, transfer-done enable at bit 7, threshold enable at bit 8 and status-match enable at bit 9. A 1 enables the source.
- R7: An event input pulse sets its sticky bit, which stays set until the matching `ev_clr` bit is high on a clock edge. `ev_clr` bit 0 clears transfer error, bit 1 clears transfer done and bit 2 clears status match. A set and a clear on the same edge leave the bit set.
- R8: A push attempt (valid high) on the active push port while 16 bytes are stored changes nothing in the buffer, and `fifo_err` is high for exactly the next cycle.
- R9: A pop attempt (ready high) on the active pop port while the buffer is empty pulses `fifo_err` high for exactly the next cycle.
- R10: The flash-select bit (control bit 10) and the dual-flash bit (bit 11) are updated by a control write only when `busy` is low. All other control fields are updated regardless of `busy`.
- R11: `flash_sel` is 2'b11 when dual-flash is 1, regardless of the flash-select bit. Otherwise it is 2'b01 for flash-select 0 and 2'b10 for flash-select 1.
- R12: Reset empties the buffer, clears the sticky events and sets every control field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Engine busy, blocks flash-select field writes |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 12 | Control word write data |
| cfg_q | output | 12 | Current control word |
| h_in_valid | input | 1 | Host push valid |
| h_in_ready | output | 1 | Host push ready |
| h_in_data | input | 8 | Host push byte |
| h_out_valid | output | 1 | Host pop valid |
| h_out_ready | input | 1 | Host pop ready |
| h_out_data | output | 8 | Host pop byte |
| e_in_valid | input | 1 | Engine push valid |
| e_in_ready | output | 1 | Engine push ready |
| e_in_data | input | 8 | Engine push byte |
| e_out_valid | output | 1 | Engine pop valid |
| e_out_ready | input | 1 | Engine pop ready |
| e_out_data | output | 8 | Engine pop byte |
| ev_xfer_err | input | 1 | Transfer error event pulse |
| ev_xfer_done | input | 1 | Transfer done event pulse |
| ev_stat_match | input | 1 | Status match event pulse |
| ev_clr | input | 3 | Sticky event clear, one bit per event |
| lvl_flag | output | 1 | Threshold level flag |
| irq | output | 1 | Gated interrupt request |
| fifo_err | output | 1 | One-cycle pulse on overflow or underflow attempt |
| flash_sel | output | 2 | Flash device select, bit 0 first device, bit 1 second |

## Verification
The bench moves each threshold across its edge in both directions. This includes code 15 with an empty and a full buffer and code 0 at one byte from each end. A design that counted stored bytes in write direction, or took N literally instead of N+1, would flip the flag on the wrong side of the edge. Pushes into a full buffer and pops from an empty one are tried on purpose. The buffer is then drained and counted, so a design that let an overflow byte in or missed the error pulse is exposed. The bench also writes flash-select while busy, sets dual-flash over flash-select 1, and issues a set and a clear on the same edge. These catch a design that ignores the busy gate, lets flash-select win over dual-flash, or lets the clear win.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned THR_W      = $clog2(FIFO_DEPTH);
  localparam int unsigned NUM_EVT    = 3;

  typedef enum logic [1:0] {
    DIR_WR = 2'b00,
    DIR_RD = 2'b01,
    DIR_X2 = 2'b10,
    DIR_X3 = 2'b11
  } dir_e;

  typedef struct packed {
    logic             dual;
    logic             fsel;
    logic             en_smatch;
    logic             en_thr;
    logic             en_tdone;
    logic             en_terr;
    dir_e             dir;
    logic [THR_W-1:0] thr;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ffc_ctl_reg.sv
module ffc_ctl_reg
  import ffc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic busy,
  input  ctl_t wdata,
  output ctl_t ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.thr       <= wdata.thr;
      ctl.dir       <= wdata.dir;
      ctl.en_terr   <= wdata.en_terr;
      ctl.en_tdone  <= wdata.en_tdone;
      ctl.en_thr    <= wdata.en_thr;
      ctl.en_smatch <= wdata.en_smatch;
      if (!busy) begin
        ctl.fsel <= wdata.fsel;
        ctl.dual <= wdata.dual;
      end
    end
  end
endmodule

// File: rtl/ffc_byte_fifo.sv
module ffc_byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  assign pop_data = mem[rptr];
  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);
endmodule

// File: rtl/ffc_level_flag.sv
module ffc_level_flag
  import ffc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] level,
  input  dir_e          dir,
  input  logic [TW-1:0] thr,
  output logic          flag
);
  logic [CW-1:0] need, room;

  always_comb begin
    need = CW'(thr) + CW'(1);
    room = CW'(DEPTH) - level;
    case (dir)
      DIR_WR:  flag = (room >= need);
      DIR_RD:  flag = (level >= need);
      default: flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/ffc_irq_unit.sv
module ffc_irq_unit #(
  parameter int unsigned NE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] ev,
  input  logic [NE-1:0] clr,
  input  logic [NE-1:0] en,
  input  logic          thr_flag,
  input  logic          thr_en,
  output logic          irq
);
  logic [NE-1:0] sticky;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr) | ev;
  end

  assign irq = (|(sticky & en)) | (thr_flag & thr_en);
endmodule

// File: rtl/ffc_top.sv
module ffc_top
  import ffc_pkg::*;
#(
  parameter int unsigned DW    = BYTE_W,
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 cfg_we,
  input  logic [CTL_W-1:0]     cfg_wdata,
  output logic [CTL_W-1:0]     cfg_q,
  input  logic                 h_in_valid,
  output logic                 h_in_ready,
  input  logic [DW-1:0]        h_in_data,
  output logic                 h_out_valid,
  input  logic                 h_out_ready,
  output logic [DW-1:0]        h_out_data,
  input  logic                 e_in_valid,
  output logic                 e_in_ready,
  input  logic [DW-1:0]        e_in_data,
  output logic                 e_out_valid,
  input  logic                 e_out_ready,
  output logic [DW-1:0]        e_out_data,
  input  logic                 ev_xfer_err,
  input  logic                 ev_xfer_done,
  input  logic                 ev_stat_match,
  input  logic [NUM_EVT-1:0]   ev_clr,
  output logic                 lvl_flag,
  output logic                 irq,
  output logic                 fifo_err,
  output logic [1:0]           flash_sel
);
  ctl_t          ctl;
  logic          is_wr, is_rd;
  logic          push_v, pop_r, push, pop, full, empty;
  logic [DW-1:0] push_d, pop_d;
  logic [CW-1:0] level;
  logic          err_q;

  ffc_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .busy  (busy),
    .wdata (ctl_t'(cfg_wdata)),
    .ctl   (ctl)
  );

  assign is_wr = (ctl.dir == DIR_WR);
  assign is_rd = (ctl.dir == DIR_RD);

  always_comb begin
    push_v = 1'b0;
    push_d = '0;
    pop_r  = 1'b0;
    if (is_wr) begin
      push_v = h_in_valid;
      push_d = h_in_data;
      pop_r  = e_out_ready;
    end else if (is_rd) begin
      push_v = e_in_valid;
      push_d = e_in_data;
      pop_r  = h_out_ready;
    end
  end

  assign push = push_v & ~full;
  assign pop  = pop_r & ~empty;

  ffc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_d),
    .pop       (pop),
    .pop_data  (pop_d),
    .level     (level),
    .full      (full),
    .empty     (empty)
  );

  assign h_in_ready  = is_wr & ~full;
  assign e_in_ready  = is_rd & ~full;
  assign h_out_valid = is_rd & ~empty;
  assign e_out_valid = is_wr & ~empty;
  assign h_out_data  = pop_d;
  assign e_out_data  = pop_d;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (push_v & full) | (pop_r & empty);
  end
  assign fifo_err = err_q;

  ffc_level_flag #(.DEPTH(DEPTH), .TW(THR_W)) u_flag (
    .level (level),
    .dir   (ctl.dir),
    .thr   (ctl.thr),
    .flag  (lvl_flag)
  );

  ffc_irq_unit #(.NE(NUM_EVT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       ({ev_stat_match, ev_xfer_done, ev_xfer_err}),
    .clr      (ev_clr),
    .en       ({ctl.en_smatch, ctl.en_tdone, ctl.en_terr}),
    .thr_flag (lvl_flag),
    .thr_en   (ctl.en_thr),
    .irq      (irq)
  );

  assign flash_sel = ctl.dual ? 2'b11 : (ctl.fsel ? 2'b10 : 2'b01);
  assign cfg_q     = ctl;
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned CTLW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [CTLW-1:0] cfg_q,
  input logic            h_in_valid,
  input logic            h_in_ready,
  input logic            h_out_valid,
  input logic            e_out_valid,
  input logic            e_out_ready,
  input logic            fifo_err,
  input logic            lvl_flag,
  input logic            irq,
  input logic [1:0]      flash_sel,
  input logic [CW-1:0]   level
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R8
  push_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b00 && h_in_valid && !h_in_ready) |=> fifo_err);

  // R9
  pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b00 && e_out_ready && !e_out_valid) |=> fifo_err);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(flash_sel));

  // R5
  idle_dir_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[5] |-> !lvl_flag);

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[9:6] == 4'b0000) |-> !irq);

  // R2
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] != 2'b00) |-> (!h_in_ready && !e_out_valid));

  // R4
  rd_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b01 && !h_out_valid) |-> !lvl_flag);
endmodule

bind ffc_top ffc_checker #(.DEPTH(DEPTH), .CW(CW), .CTLW(ffc_pkg::CTL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .cfg_q       (cfg_q),
  .h_in_valid  (h_in_valid),
  .h_in_ready  (h_in_ready),
  .h_out_valid (h_out_valid),
  .e_out_valid (e_out_valid),
  .e_out_ready (e_out_ready),
  .fifo_err    (fifo_err),
  .lvl_flag    (lvl_flag),
  .irq         (irq),
  .flash_sel   (flash_sel),
  .level       (level)
);

// File: tb/sim_ffc_top.sv
`timescale 1ns/1ps
module sim_ffc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] cfg_q;
  logic        h_in_valid = 1'b0, h_in_ready;
  logic [7:0]  h_in_data = '0;
  logic        h_out_valid, h_out_ready = 1'b0;
  logic [7:0]  h_out_data;
  logic        e_in_valid = 1'b0, e_in_ready;
  logic [7:0]  e_in_data = '0;
  logic        e_out_valid, e_out_ready = 1'b0;
  logic [7:0]  e_out_data;
  logic        ev_xfer_err = 1'b0, ev_xfer_done = 1'b0, ev_stat_match = 1'b0;
  logic [2:0]  ev_clr = '0;
  logic        lvl_flag, irq, fifo_err;
  logic [1:0]  flash_sel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ffc_top u0 (.*);

  // {dir[11:10], thr[9:6], fill[5:1], expected flag[0]}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 4'd3,  5'd12, 1'b1}, {2'b00, 4'd3,  5'd13, 1'b0},
    {2'b00, 4'd15, 5'd0,  1'b1}, {2'b00, 4'd15, 5'd1,  1'b0},
    {2'b00, 4'd0,  5'd15, 1'b1}, {2'b00, 4'd0,  5'd16, 1'b0},
    {2'b01, 4'd3,  5'd4,  1'b1}, {2'b01, 4'd3,  5'd3,  1'b0},
    {2'b01, 4'd15, 5'd16, 1'b1}, {2'b01, 4'd15, 5'd15, 1'b0},
    {2'b01, 4'd0,  5'd1,  1'b1}, {2'b01, 4'd0,  5'd0,  1'b0},
    {2'b10, 4'd0,  5'd0,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic dual, input logic fsel, input logic [3:0] en,
                     input logic [1:0] dir, input logic [3:0] thr);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {dual, fsel, en, dir, thr};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_h(input logic [7:0] d);
    @(negedge clk);
    h_in_valid = 1'b1; h_in_data = d;
    @(negedge clk);
    h_in_valid = 1'b0;
  endtask

  task automatic push_e(input logic [7:0] d);
    @(negedge clk);
    e_in_valid = 1'b1; e_in_data = d;
    @(negedge clk);
    e_in_valid = 1'b0;
  endtask

  task automatic pop_e(output logic [7:0] d);
    @(negedge clk);
    d = e_out_data;
    e_out_ready = 1'b1;
    @(negedge clk);
    e_out_ready = 1'b0;
  endtask

  task automatic pop_h(output logic [7:0] d);
    @(negedge clk);
    d = h_out_data;
    h_out_ready = 1'b1;
    @(negedge clk);
    h_out_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int n;
    do_reset();
    @(negedge clk);
    // R12: reset state
    chk("R12 cfg_q", cfg_q, 12'h000);
    chk("R12 h_in_ready", h_in_ready, 1);
    chk("R12 e_out_valid", e_out_valid, 0);
    chk("R12 irq", irq, 0);
    chk("R12 fifo_err", fifo_err, 0);
    chk("R11 flash_sel reset", flash_sel, 2'b01);
    chk("R3 flag empty thr0", lvl_flag, 1);

    // R3 R4 R5 R6: threshold vectors
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      string req;
      v = VEC[i];
      req = (v[11:10] == 2'b00) ? "R3" : (v[11:10] == 2'b01) ? "R4" : "R5";
      do_reset();
      cfg(1'b0, 1'b0, 4'b0100, v[11:10], v[9:6]);
      for (int k = 0; k < int'(v[5:1]); k++) begin
        if (v[11:10] == 2'b00) push_h(8'(k));
        else push_e(8'(k));
      end
      chk(req, lvl_flag, v[0]);
      chk("R6 thr irq", irq, v[0]);
    end

    // R1 R8: order, full, overflow ignored
    do_reset();
    for (int k = 0; k < 16; k++) push_h(8'(8'h40 + k));
    chk("R1 ready low when full", h_in_ready, 0);
    @(negedge clk);
    h_in_valid = 1'b1; h_in_data = 8'hEE;
    @(negedge clk);
    h_in_valid = 1'b0;
    chk("R8 err pulse", fifo_err, 1);
    @(negedge clk);
    chk("R8 err one cycle", fifo_err, 0);
    n = 0;
    for (int k = 0; k < 16; k++) begin
      pop_e(b);
      if (b !== 8'(8'h40 + k)) n++;
    end
    chk("R1 order", n, 0);
    chk("R8 no extra byte", e_out_valid, 0);

    // R9: underflow
    @(negedge clk);
    e_out_ready = 1'b1;
    @(negedge clk);
    e_out_ready = 1'b0;
    chk("R9 err pulse", fifo_err, 1);
    @(negedge clk);
    chk("R9 err one cycle", fifo_err, 0);

    // R2: read direction
    cfg(1'b0, 1'b0, 4'b0000, 2'b01, 4'd0);
    chk("R2 host push off", h_in_ready, 0);
    chk("R2 engine push on", e_in_ready, 1);
    push_e(8'h5A);
    push_e(8'hC3);
    chk("R2 host valid", h_out_valid, 1);
    chk("R2 engine valid off", e_out_valid, 0);
    pop_h(b);
    chk("R2 data 1", b, 8'h5A);
    pop_h(b);
    chk("R2 data 2", b, 8'hC3);

    // R10: busy gate
    do_reset();
    busy = 1'b1;
    cfg(1'b0, 1'b1, 4'b0000, 2'b00, 4'd7);
    chk("R10 fsel held", flash_sel, 2'b01);
    chk("R10 thr written", cfg_q[3:0], 4'd7);
    busy = 1'b0;
    cfg(1'b0, 1'b1, 4'b0000, 2'b00, 4'd7);
    chk("R10 fsel written", flash_sel, 2'b10);

    // R11: dual overrides fsel
    cfg(1'b1, 1'b1, 4'b0000, 2'b00, 4'd0);
    chk("R11 dual fsel1", flash_sel, 2'b11);
    cfg(1'b1, 1'b0, 4'b0000, 2'b00, 4'd0);
    chk("R11 dual fsel0", flash_sel, 2'b11);

    // R6 R7: event latching and masking
    do_reset();
    cfg(1'b0, 1'b0, 4'b0001, 2'b10, 4'd0);
    @(negedge clk); ev_xfer_err = 1'b1;
    @(negedge clk); ev_xfer_err = 1'b0;
    @(negedge clk);
    chk("R7 error sticky", irq, 1);
    @(negedge clk); ev_clr = 3'b001;
    @(negedge clk); ev_clr = 3'b000;
    chk("R7 error cleared", irq, 0);
    @(negedge clk); ev_xfer_done = 1'b1;
    @(negedge clk); ev_xfer_done = 1'b0;
    chk("R6 done masked", irq, 0);
    cfg(1'b0, 1'b0, 4'b0010, 2'b10, 4'd0);
    chk("R6 done enabled", irq, 1);
    cfg(1'b0, 1'b0, 4'b1000, 2'b10, 4'd0);
    @(negedge clk); ev_stat_match = 1'b1; ev_clr = 3'b100;
    @(negedge clk); ev_stat_match = 1'b0; ev_clr = 3'b000;
    chk("R7 set wins", irq, 1);
    @(negedge clk); ev_clr = 3'b100;
    @(negedge clk); ev_clr = 3'b000;
    chk("R7 match cleared", irq, 0);

    finish_run();
  end
endmodule